// File: doc/BRIEF.md
# Asynchronous serial transmitter with break and idle generation

This block drives one asynchronous serial output line. A byte, or a nine-bit word in the wider mode, is written into a holding register. When the line is free, the word moves into a shift register, framed by a low start bit and a high stop bit. The bits leave least significant first, one bit per baud tick. The baud tick is a single-cycle strobe supplied from outside.

Besides data, the block sends two special characters. An idle character is a run of ones; one is sent automatically each time the transmitter is enabled. A break character is a run of zeros, sent for as long as the break request is held. After the last break, a single one bit guarantees that the next start edge is seen. A flag reports when the holding register can take a new word, and a maskable interrupt request follows that flag.

Top module: `async_tx_engine`

## Requirements
- R1: After reset the line is 1, the empty flag is 1 and no character is in progress.
- R2: On each rising edge of the enable, an idle preamble is queued. It is 10 ones in 8-bit mode and 11 in 9-bit mode, and it is sent before any held data word.
- R3: A data character is, in time order: start bit 0, data bits 0..7, data bit 8 (9-bit mode only), then stop bit 1. That is 10 or 11 bits, one per baud tick. The next character begins on the tick after the stop bit.
- R4: A write clears the empty flag. The flag sets on the baud tick that moves the held word into the shift register.
- R5: The interrupt request equals the empty flag ANDed with the interrupt enable.
- R6: The line is 1 whenever no character is in progress. While the enable is 0, a held word is not sent.
- R7: With the enable at 1, a break request sends a character of all zeros. Its length is 10 in 8-bit mode and 11 in 9-bit mode, plus 1 in long-break mode. With the enable at 0, the request has no effect.
- R8: Breaks repeat back to back while the request stays at 1. After the last break, one 1 bit is sent before any further character. A break takes priority over a pending data word.
- R9: Clearing the enable during a character lets it finish. The line then rests at 1, and the held word stays pending until the next enable.
- R10: Clearing and re-setting the enable during a character queues one idle character. It follows the current character and comes before the next data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Break request, level sensitive |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| long_brk | input | 1 | 1 lengthens breaks by one bit |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data bits 0..7 of the word to send |
| wr_bit8 | input | 1 | Ninth data bit, used in 9-bit mode |
| irq_en | input | 1 | Interrupt enable for the empty flag |
| tx_line | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a word |
| irq | output | 1 | Interrupt request |

## Verification
A table of words covers alternating patterns, all zeros and all ones, in both character widths. Because the ninth bit is set in some rows and clear in others, an unplaced or misplaced ninth bit shows up. Back-to-back writes show whether a gap is inserted between frames. A word written before enabling shows the preamble, since its start bit must arrive only after ten ones. Breaks are tried held over two characters, released at once in each width and long-break combination, and followed by pending data; together these show the break length, the repeat, and the trailing one bit. Enable toggles in the middle of a frame tell a queued idle character apart from a plain completion.

// File: rtl/atx_pkg.sv
package atx_pkg;

   // Kind of character the scheduler asks the shifter to load.
   typedef enum logic [2:0] {
      CH_NONE  = 3'd0,
      CH_DATA  = 3'd1,
      CH_IDLE  = 3'd2,
      CH_BREAK = 3'd3,
      CH_MARK  = 3'd4
   } ch_kind_e;

endpackage

// File: rtl/atx_holdreg.sv
module atx_holdreg #(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_b8_i,
   input  logic              xfer_i,
   input  logic              irq_en_i,
   output logic [DATA_W:0]   data_o,
   output logic              empty_o,
   output logic              irq_o
);

   logic [DATA_W:0] data_q;
   logic            empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         empty_q <= 1'b1;
      end else begin
         if (wr_i) begin
            data_q  <= {wr_b8_i, wr_data_i};
            empty_q <= 1'b0;
         end else if (xfer_i) begin
            empty_q <= 1'b1;
         end
      end
   end

   assign data_o  = data_q;
   assign empty_o = empty_q;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= empty_q & irq_en_i;
         end
         assign irq_o = irq_q;

         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (empty_q && irq_en_i) |=> irq_o); // R5
      end else begin : g_irq_comb
         assign irq_o = empty_q & irq_en_i;
      end
   endgenerate

   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !empty_o); // R4

   AST_XFER_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !wr_i) |=> empty_o); // R4

endmodule

// File: rtl/atx_sched.sv
module atx_sched
   import atx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tx_en_i,
   input  logic     brk_i,
   input  logic     tick_i,
   input  logic     shift_idle_i,
   input  logic     empty_i,
   output logic     load_o,
   output ch_kind_e kind_o
);

   logic en_q;     // enable seen on the previous cycle
   logic pend_q;   // idle character queued
   logic tail_q;   // a one bit is owed after a break
   logic rise;
   logic pend_eff;
   logic boundary;

   assign rise     = tx_en_i & ~en_q;
   assign pend_eff = pend_q | rise;
   assign boundary = tick_i & shift_idle_i;

   // Priority at a character boundary: break, break tail, idle, data.
   always_comb begin
      kind_o = CH_NONE;
      if (boundary) begin
         if (tx_en_i && brk_i)            kind_o = CH_BREAK;
         else if (tail_q)                 kind_o = CH_MARK;
         else if (tx_en_i && pend_eff)    kind_o = CH_IDLE;
         else if (tx_en_i && !empty_i)    kind_o = CH_DATA;
         else                             kind_o = CH_NONE;
      end
   end

   assign load_o = (kind_o != CH_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         tail_q <= 1'b0;
      end else begin
         en_q <= tx_en_i;
         if (!tx_en_i)                pend_q <= 1'b0;
         else if (kind_o == CH_IDLE)  pend_q <= 1'b0;
         else if (rise)               pend_q <= 1'b1;

         if (kind_o == CH_BREAK)      tail_q <= 1'b1;
         else if (kind_o == CH_MARK)  tail_q <= 1'b0;
      end
   end

   AST_NO_DATA_BEFORE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(kind_o == CH_BREAK) && !brk_i) |-> (kind_o != CH_DATA)); // R8

endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
   import atx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            load_i,
   input  ch_kind_e        kind_i,
   input  logic            nine_i,
   input  logic            long_i,
   input  logic [DATA_W:0] data_i,
   output logic            idle_o,
   output logic            line_o
);

   localparam int SH_W  = DATA_W + 4;           // longest character: long 9-bit break
   localparam int CNT_W = $clog2(SH_W + 1);
   localparam int BASE  = DATA_W + 2;           // start + data + stop

   logic [SH_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;                     // bits still to leave after the current one
   logic             line_q;
   logic [SH_W-1:0]  word;
   logic [CNT_W-1:0] len;

   always_comb begin
      word = '1;
      len  = CNT_W'(1);
      unique case (kind_i)
         CH_DATA: begin
            word[0]          = 1'b0;
            word[DATA_W:1]   = data_i[DATA_W-1:0];
            word[DATA_W+1]   = nine_i ? data_i[DATA_W] : 1'b1;
            len              = CNT_W'(BASE + int'(nine_i));
         end
         CH_IDLE: begin
            len = CNT_W'(BASE + int'(nine_i));
         end
         CH_BREAK: begin
            word = '0;
            len  = CNT_W'(BASE + int'(nine_i) + int'(long_i));
         end
         CH_MARK: begin
            len = CNT_W'(1);
         end
         default: begin
            word = '1;
            len  = CNT_W'(1);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         cnt_q  <= '0;
         line_q <= 1'b1;
      end else if (load_i) begin
         line_q <= word[0];
         sh_q   <= {1'b1, word[SH_W-1:1]};
         cnt_q  <= len - CNT_W'(1);
      end else if (tick_i) begin
         if (cnt_q != '0) begin
            line_q <= sh_q[0];
            sh_q   <= {1'b1, sh_q[SH_W-1:1]};
            cnt_q  <= cnt_q - CNT_W'(1);
         end else begin
            line_q <= 1'b1;
         end
      end
   end

   assign idle_o = (cnt_q == '0);
   assign line_o = line_q;

   AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (tick_i && cnt_q == '0)); // R3

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(SH_W)); // R3

   AST_LINE_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && cnt_q == '0 && !load_i) |=> line_o); // R6

   AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && kind_i == CH_BREAK) |=> !line_o); // R7

endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
   import atx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              brk_req,
   input  logic              nine_bit,
   input  logic              long_brk,
   input  logic              baud_tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit8,
   input  logic              irq_en,
   output logic              tx_line,
   output logic              hold_empty,
   output logic              irq
);

   initial begin
      assert (DATA_W >= 5 && DATA_W <= 16)
         else $error("async_tx_engine: DATA_W out of range");
   end

   logic            load;
   ch_kind_e        kind;
   logic            shift_idle;
   logic [DATA_W:0] held;
   logic            xfer;

   assign xfer = load && (kind == CH_DATA);

   atx_holdreg #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_stb),
      .wr_data_i (wr_data),
      .wr_b8_i   (wr_bit8),
      .xfer_i    (xfer),
      .irq_en_i  (irq_en),
      .data_o    (held),
      .empty_o   (hold_empty),
      .irq_o     (irq)
   );

   atx_sched u_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_en_i      (tx_en),
      .brk_i        (brk_req),
      .tick_i       (baud_tick),
      .shift_idle_i (shift_idle),
      .empty_i      (hold_empty),
      .load_o       (load),
      .kind_o       (kind)
   );

   atx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (baud_tick),
      .load_i (load),
      .kind_i (kind),
      .nine_i (nine_bit),
      .long_i (long_brk),
      .data_i (held),
      .idle_o (shift_idle),
      .line_o (tx_line)
   );

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && $past(!tx_en) && shift_idle && !load) |=> tx_line); // R6

endmodule

// File: tb/async_tx_engine_tb.sv
`timescale 1ns/1ps
module async_tx_engine_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, brk_req = 1'b0, nine_bit = 1'b0, long_brk = 1'b0;
   logic       baud_tick = 1'b0, wr_stb = 1'b0, wr_bit8 = 1'b0, irq_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       tx_line, hold_empty, irq;

   always #4 clk = ~clk;

   async_tx_engine u_dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
      .nine_bit(nine_bit), .long_brk(long_brk), .baud_tick(baud_tick),
      .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit8(wr_bit8), .irq_en(irq_en),
      .tx_line(tx_line), .hold_empty(hold_empty), .irq(irq)
   );

   int n_chk = 0, n_err = 0;
   logic [127:0] ev = '0;
   int en = 0;
   int act_at = -1, act_code = 0;
   logic [8:0] act_d = '0;
   bit finished = 1'b0;

   // bit 9: 9-bit mode, bits 8..0: word
   localparam logic [9:0] VEC [7] = '{10'h055, 10'h0A3, 10'h000, 10'h0FF,
                                      10'h381, 10'h27E, 10'h3FF};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [8:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_data = d[7:0]; wr_bit8 = d[8];
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic tick_bit(output logic b);
      @(negedge clk); baud_tick = 1'b1;
      @(negedge clk); baud_tick = 1'b0;
      b = tx_line;
   endtask

   task automatic push_bit(input logic b);
      ev[en] = b; en++;
   endtask

   task automatic push_run(input logic b, input int n);
      for (int i = 0; i < n; i++) push_bit(b);
   endtask

   function automatic logic frame_bit(input logic [8:0] d, input logic nine, input int i);
      if (i == 0) return 1'b0;
      if (i <= 8) return d[i-1];
      if (nine && i == 9) return d[8];
      return 1'b1;
   endfunction

   task automatic push_frame(input logic [8:0] d, input logic nine, input int from);
      for (int i = from; i < 10 + int'(nine); i++) push_bit(frame_bit(d, nine, i));
   endtask

   task automatic do_act();
      case (act_code)
         1: write_word(act_d);
         2: begin @(negedge clk); brk_req = 1'b0; end
         3: begin write_word(act_d); @(negedge clk); tx_en = 1'b0; @(negedge clk); tx_en = 1'b1; end
         4: begin write_word(act_d); @(negedge clk); tx_en = 1'b0; end
         default: ;
      endcase
   endtask

   task automatic run_expect(input string req);
      int bad = -1;
      logic b, gotb = 1'b0;
      for (int k = 0; k < en; k++) begin
         tick_bit(b);
         if (b !== ev[k] && bad < 0) begin bad = k; gotb = b; end
         if (k == act_at) do_act();
      end
      n_chk++;
      if (bad >= 0) begin
         n_err++;
         $display("FAIL %s bit %0d actual=%b expected=%b", req, bad, gotb, ev[bad]);
      end
      en = 0; act_at = -1; act_code = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic b;
      repeat (3) @(negedge clk);
      chk(tx_line === 1'b1, "R1 line in reset", int'(tx_line), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_line === 1'b1, "R1 line", int'(tx_line), 1);
      chk(hold_empty === 1'b1, "R1 empty", int'(hold_empty), 1);
      chk(irq === 1'b0, "R5 masked", int'(irq), 0);
      irq_en = 1'b1; @(negedge clk);
      chk(irq === 1'b1, "R5 unmasked", int'(irq), 1);
      irq_en = 1'b0;

      // R6: held word is not sent while disabled
      write_word(9'h011);
      chk(hold_empty === 1'b0, "R4 write clears empty", int'(hold_empty), 0);
      push_run(1'b1, 12); run_expect("R6 disabled");
      chk(hold_empty === 1'b0, "R6 word kept", int'(hold_empty), 0);

      // R2: preamble before the held word
      @(negedge clk); tx_en = 1'b1; @(negedge clk);
      push_run(1'b1, 10); run_expect("R2 preamble");
      chk(hold_empty === 1'b0, "R2 word still held", int'(hold_empty), 0);
      tick_bit(b);
      chk(b === 1'b0, "R3 start bit", int'(b), 0);
      chk(hold_empty === 1'b1, "R4 set on transfer", int'(hold_empty), 1);
      irq_en = 1'b1; @(negedge clk);
      chk(irq === 1'b1, "R5 empty irq", int'(irq), 1);
      irq_en = 1'b0;
      push_frame(9'h011, 1'b0, 1); push_bit(1'b1); run_expect("R3 rest of frame");

      // R3: vector table in both widths
      foreach (VEC[i]) begin
         nine_bit = VEC[i][9];
         write_word(VEC[i][8:0]);
         push_frame(VEC[i][8:0], VEC[i][9], 0); push_bit(1'b1);
         run_expect($sformatf("R3 vector %0d", i));
      end
      nine_bit = 1'b0;

      // R3: back-to-back frames
      write_word(9'h03C);
      push_frame(9'h03C, 1'b0, 0); push_frame(9'h0C5, 1'b0, 0); push_bit(1'b1);
      act_at = 0; act_code = 1; act_d = 9'h0C5;
      run_expect("R3 back-to-back");

      // R8: repeated break, then one 1 bit
      brk_req = 1'b1;
      push_run(1'b0, 20); push_run(1'b1, 2);
      act_at = 12; act_code = 2;
      run_expect("R8 repeat");

      // R7: break lengths
      nine_bit = 1'b1; long_brk = 1'b1; brk_req = 1'b1;
      push_run(1'b0, 12); push_run(1'b1, 2); act_at = 0; act_code = 2;
      run_expect("R7 long 9-bit");
      nine_bit = 1'b0; long_brk = 1'b1; brk_req = 1'b1;
      push_run(1'b0, 11); push_run(1'b1, 2); act_at = 0; act_code = 2;
      run_expect("R7 long 8-bit");
      nine_bit = 1'b1; long_brk = 1'b0; brk_req = 1'b1;
      push_run(1'b0, 11); push_run(1'b1, 2); act_at = 0; act_code = 2;
      run_expect("R7 9-bit");
      nine_bit = 1'b0; long_brk = 1'b0;

      // R8: break beats pending data, tail bit precedes it
      write_word(9'h05A);
      brk_req = 1'b1;
      push_run(1'b0, 10); push_bit(1'b1); push_frame(9'h05A, 1'b0, 0); push_bit(1'b1);
      act_at = 1; act_code = 2;
      run_expect("R8 tail before data");

      // R10: enable toggle mid-frame queues an idle character
      write_word(9'h096);
      push_frame(9'h096, 1'b0, 0); push_run(1'b1, 10); push_frame(9'h0E1, 1'b0, 0); push_bit(1'b1);
      act_at = 2; act_code = 3; act_d = 9'h0E1;
      run_expect("R10 queued idle");

      // R9: disable mid-frame, frame completes, next word held
      write_word(9'h03F);
      push_frame(9'h03F, 1'b0, 0); push_run(1'b1, 8);
      act_at = 3; act_code = 4; act_d = 9'h081;
      run_expect("R9 finish frame");
      chk(hold_empty === 1'b0, "R9 word held", int'(hold_empty), 0);
      @(negedge clk); tx_en = 1'b1;
      push_run(1'b1, 10); push_frame(9'h081, 1'b0, 0); push_bit(1'b1);
      run_expect("R9 sent after re-enable");
      chk(hold_empty === 1'b1, "R4 empty after send", int'(hold_empty), 1);

      // R7: break ignored while disabled
      @(negedge clk); tx_en = 1'b0; brk_req = 1'b1;
      push_run(1'b1, 12); run_expect("R7 disabled break");
      brk_req = 1'b0;

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule